// File: doc/BRIEF.md
# Random Generator FIFO Controller

This block is the software-facing front end of a random number generator. A small 32-bit register port, a plain valid/ready request channel with registered read responses, gives software a control word, a count of buffered words, a status word that carries the run state, and a data port that pops one random word per read. Behind the port a six-state run machine brings the generator out of reset, through a programmable warm-up period, and into normal running. While running it moves words from a noise source into a word FIFO. It pauses filling when the FIFO is full and resumes when software drains it.

The noise source is modelled as a 32-bit xorshift generator. A health-fail input stands in for the entropy health monitor. A health failure puts the machine into a sticky error state. In that state nothing is stored and the data port stops handing out words. Software recovers by pulsing soft reset and then writing enable again. The machine leaves the reset state on the first enabled cycle and reaches running after the warm-up count, which is far inside a millisecond at any practical clock.

Top module: `rng_fifo_ctrl`

## Requirements
- R1: Offset 0x00 is the control word. A write stores bit 0 as enable and bit 8 as soft reset, and a read returns both at those positions with all other bits 0. Writes to any offset other than 0x00 change nothing.
- R2: A read of offset 0x04 returns the number of words held in the FIFO. It returns 0 while soft reset is set.
- R3: A read of offset 0x30 returns the run state in bits 3:1, with all other bits 0. The encoding is 0 reset, 1 startup, 2 full-on, 3 full-off, 4 running, 5 error.
- R4: A read of offset 0x80 returns the oldest FIFO word and removes it. With an empty FIFO the read returns 0 and the level stays unchanged.
- R5: While soft reset is set, the FIFO is emptied and the state is forced to reset one cycle later. Data reads return 0 while soft reset is set.
- R6: Each cycle the machine is outside error, clearing enable sends it to reset. With enable set, reset moves to startup. Startup lasts WARMUP cycles and then moves to running.
- R7: In running and full-off, one word per cycle enters the FIFO while it holds fewer than DEPTH words. The words are successive xorshift32 values (x^=x<<13, x^=x>>17, x^=x<<5) starting from SEED. The generator advances only when a word is stored.
- R8: A running machine that sees DEPTH words goes to full-on, and filling stops. When the level drops below DEPTH it goes to full-off for exactly one cycle and then returns to running.
- R9: A health failure seen in startup, running, full-on or full-off moves the machine to error. It is ignored in reset. Error persists, whatever enable does, until soft reset. In error no word is stored, and data reads return 0 without removing a word.
- R10: The request channel is always ready. Every read is answered with rsp_valid_o one cycle later, writes produce no response, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready (always 1) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_rdata_o | output | 32 | Read response data |
| health_fail_i | input | 1 | Entropy health failure indication |

## Verification
The bench builds the block with DEPTH 8 and WARMUP 8 and a fixed seed. With these values the whole life cycle fits in a few hundred cycles: warm-up, filling to full, the full-on to full-off to running loop under repeated reads, and draining to empty. It also covers error entry from running, error persisting across enable writes, and soft-reset recovery. A behavioural queue model predicts every response, including the exact random words, so a wrong fill cycle, a missed pause or a word stored in error shows up as a data or level mismatch.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef enum logic [2:0] {
    ST_RESET    = 3'd0,
    ST_START    = 3'd1,
    ST_FULL_ON  = 3'd2,
    ST_FULL_OFF = 3'd3,
    ST_RUN      = 3'd4,
    ST_ERROR    = 3'd5
  } run_state_e;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_LEVEL  = 8'h04;
  localparam logic [7:0] OFS_STATUS = 8'h30;
  localparam logic [7:0] OFS_DATA   = 8'h80;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SRST_BIT = 8;
  localparam int STATE_LSB     = 1;
endpackage

// File: rtl/rfc_noise.sv
module rfc_noise #(
  parameter logic [31:0] SEED = 32'h1357_9BDF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        step_i,
  output logic [31:0] word_o
);
  logic [31:0] x_q, x_d;

  always_comb begin
    x_d = x_q ^ (x_q << 13);
    x_d = x_d ^ (x_d >> 17);
    x_d = x_d ^ (x_d << 5);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     x_q <= SEED;
    else if (step_i) x_q <= x_d;
  end

  assign word_o = x_q;
endmodule

// File: rtl/rfc_fifo.sv
module rfc_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= bump(wptr_q);
      if (pop_i)  rptr_q <= bump(rptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/rfc_run_fsm.sv
module rfc_run_fsm
  import rfc_pkg::*;
#(
  parameter int WARMUP = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       srst_i,
  input  logic       en_i,
  input  logic       health_i,
  input  logic       full_i,
  output run_state_e state_o,
  output logic       fill_o
);
  localparam int WW = (WARMUP > 1) ? $clog2(WARMUP) : 1;
  localparam logic [WW-1:0] WLAST = WW'(WARMUP - 1);

  run_state_e state_q, state_d;
  logic [WW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (srst_i) begin
      state_d = ST_RESET;
      cnt_d   = '0;
    end else if (state_q != ST_ERROR) begin
      if (!en_i) begin
        state_d = ST_RESET;
      end else if (state_q == ST_RESET) begin
        state_d = ST_START;
        cnt_d   = '0;
      end else if (health_i) begin
        state_d = ST_ERROR;
      end else begin
        case (state_q)
          ST_START:    if (cnt_q == WLAST) state_d = ST_RUN;
                       else cnt_d = cnt_q + 1'b1;
          ST_RUN:      if (full_i) state_d = ST_FULL_ON;
          ST_FULL_ON:  if (!full_i) state_d = ST_FULL_OFF;
          ST_FULL_OFF: state_d = ST_RUN;
          default:     state_d = state_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign fill_o  = (state_q == ST_RUN) || (state_q == ST_FULL_OFF);
endmodule

// File: rtl/rng_fifo_ctrl.sv
module rng_fifo_ctrl
  import rfc_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          DEPTH  = 16,
  parameter int          WARMUP = 64,
  parameter logic [31:0] SEED   = 32'h1357_9BDF,
  localparam int         CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  input  logic              health_fail_i
);
  logic          en_q, srst_q;
  logic          rsp_valid_q;
  logic [31:0]   rsp_rdata_q, rd_word;
  logic          wr_ctrl, rd_req, rd_data;
  logic          push, pop, fill, full, data_ok;
  logic [CW-1:0] fifo_cnt;
  logic [31:0]   fifo_rdata, noise_word;
  run_state_e    run_state;
  logic          unused_wdata;

  assign unused_wdata = ^{req_wdata_i[31:CTRL_SRST_BIT+1], req_wdata_i[CTRL_SRST_BIT-1:CTRL_EN_BIT+1]};

  assign req_ready_o = 1'b1;
  assign wr_ctrl = req_valid_i && req_write_i && (req_addr_i == ADDR_W'(OFS_CTRL));
  assign rd_req  = req_valid_i && !req_write_i;
  assign rd_data = rd_req && (req_addr_i == ADDR_W'(OFS_DATA));

  assign full    = (fifo_cnt == CW'(DEPTH));
  assign data_ok = !srst_q && (run_state != ST_ERROR) && (fifo_cnt != '0);
  assign pop     = rd_data && data_ok;
  assign push    = fill && !full && !srst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      srst_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q   <= req_wdata_i[CTRL_EN_BIT];
      srst_q <= req_wdata_i[CTRL_SRST_BIT];
    end
  end

  rfc_noise #(.SEED(SEED)) u_noise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (push),
    .word_o (noise_word)
  );

  rfc_fifo #(.DW(32), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (srst_q),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (noise_word),
    .rdata_o (fifo_rdata),
    .count_o (fifo_cnt)
  );

  rfc_run_fsm #(.WARMUP(WARMUP)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .srst_i   (srst_q),
    .en_i     (en_q),
    .health_i (health_fail_i),
    .full_i   (full),
    .state_o  (run_state),
    .fill_o   (fill)
  );

  always_comb begin
    rd_word = '0;
    case (req_addr_i)
      ADDR_W'(OFS_CTRL): begin
        rd_word[CTRL_EN_BIT]   = en_q;
        rd_word[CTRL_SRST_BIT] = srst_q;
      end
      ADDR_W'(OFS_LEVEL):  rd_word = srst_q ? '0 : 32'(fifo_cnt);
      ADDR_W'(OFS_STATUS): rd_word[STATE_LSB +: 3] = run_state;
      ADDR_W'(OFS_DATA):   rd_word = data_ok ? fifo_rdata : '0;
      default:             rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd_req;
      if (rd_req) rsp_rdata_q <= rd_word;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
endmodule

// File: rtl/rfc_chk.sv
module rfc_chk
  import rfc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          srst_i,
  input run_state_e    state_i,
  input logic [CW-1:0] count_i,
  input logic          push_i,
  input logic          pop_i,
  input logic          rd_req_i,
  input logic          rsp_valid_i
);
  // R5
  srst_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (state_i == ST_RESET && count_i == '0));

  // R9
  error_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ERROR && !srst_i) |=> state_i == ST_ERROR);

  // R9
  error_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_ERROR |-> (!push_i && !pop_i));

  // R8
  full_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i == CW'(DEPTH) |-> !push_i);

  // R8
  full_off_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_FULL_OFF |=> state_i != ST_FULL_OFF);

  // R4
  empty_no_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i == '0 |-> !pop_i);

  // R2
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(DEPTH));

  // R10
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rsp_valid_i);
endmodule

bind rng_fifo_ctrl rfc_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .srst_i      (srst_q),
  .state_i     (run_state),
  .count_i     (fifo_cnt),
  .push_i      (push),
  .pop_i       (pop),
  .rd_req_i    (rd_req),
  .rsp_valid_i (rsp_valid_o)
);

// File: tb/rng_fifo_ctrl_tb_top.sv
`timescale 1ns/100ps
module rng_fifo_ctrl_tb_top;
  localparam int          DEPTH  = 8;
  localparam int          WARMUP = 8;
  localparam logic [31:0] SEED   = 32'hACE1_2468;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0, health_fail_i = 1'b0;
  logic [7:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        req_ready_o, rsp_valid_o;
  logic [31:0] rsp_rdata_o;

  always #2.5 clk_i = ~clk_i;

  rng_fifo_ctrl #(.ADDR_W(8), .DEPTH(DEPTH), .WARMUP(WARMUP), .SEED(SEED)) dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_write_i, .req_addr_i,
    .req_wdata_i, .rsp_valid_o, .rsp_rdata_o, .health_fail_i
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural model
  int          m_state = 0, m_cnt = 0;
  bit          m_en = 0, m_srst = 0;
  logic [31:0] m_x = SEED;
  logic [31:0] q[$];

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic step(input bit v, input bit w, input logic [7:0] a,
                      input logic [31:0] d, input bit hf, input string tag);
    bit ev, pop, push;
    logic [31:0] ed;
    int c0;
    req_valid_i = v; req_write_i = w; req_addr_i = a; req_wdata_i = d; health_fail_i = hf;
    c0 = q.size();
    ev = v && !w;
    ed = '0;
    if (ev) begin
      case (a)
        8'h00: begin ed[0] = m_en; ed[8] = m_srst; end
        8'h04: ed = m_srst ? 0 : c0;
        8'h30: ed = m_state << 1;
        8'h80: ed = (m_srst || m_state == 5 || c0 == 0) ? 0 : q[0];
        default: ed = '0;
      endcase
    end
    pop  = ev && a == 8'h80 && !m_srst && m_state != 5 && c0 > 0;
    push = !m_srst && (m_state == 4 || m_state == 3) && c0 < DEPTH;
    if (m_srst) begin
      q.delete(); m_state = 0; m_cnt = 0;
    end else begin
      if (pop) void'(q.pop_front());
      if (push) begin q.push_back(m_x); m_x = xs(m_x); end
      if (m_state != 5) begin
        if (!m_en) m_state = 0;
        else if (m_state == 0) begin m_state = 1; m_cnt = 0; end
        else if (hf) m_state = 5;
        else case (m_state)
          1: if (m_cnt == WARMUP - 1) m_state = 4; else m_cnt++;
          4: if (c0 == DEPTH) m_state = 2;
          2: if (c0 < DEPTH) m_state = 3;
          3: m_state = 4;
          default: ;
        endcase
      end
    end
    if (v && w && a == 8'h00) begin m_en = d[0]; m_srst = d[8]; end
    @(posedge clk_i);
    @(negedge clk_i);
    n_cmp++;
    if (rsp_valid_o !== ev || (ev && rsp_rdata_o !== ed) || req_ready_o !== 1'b1) begin
      n_bad++;
      $display("FAIL %s: valid=%0b data=%h ready=%0b expected valid=%0b data=%h ready=1",
               tag, rsp_valid_o, rsp_rdata_o, req_ready_o, ev, ed);
    end
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(1, 0, a, 0, 0, tag);
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1, 1, a, d, 0, tag);
  endtask
  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2, "R10");                     // reset state: no response
    rd(8'h00, "R1");
    rd(8'h30, "R3");
    rd(8'h04, "R2");
    wr(8'h44, 32'h0000_0101, "R1");     // unmapped write ignored
    rd(8'h00, "R1");
    rd(8'h10, "R10");
    wr(8'h00, 32'h1, "R6");
    for (int i = 0; i < WARMUP + 2; i++) rd(8'h30, "R6");
    idle(DEPTH + 2, "R7");
    rd(8'h04, "R8");
    rd(8'h30, "R8");
    for (int i = 0; i < 3; i++) rd(8'h80, "R7");
    for (int i = 0; i < 4; i++) rd(8'h30, "R8");
    rd(8'h80, "R4");
    rd(8'h04, "R8");
    rd(8'h30, "R8");
    wr(8'h00, 32'h0, "R6");
    rd(8'h30, "R6");
    rd(8'h80, "R4");
    rd(8'h04, "R4");
    wr(8'h00, 32'h1, "R6");
    idle(WARMUP + 2, "R6");
    rd(8'h80, "R7");
    step(0, 0, 0, 0, 1, "R9");          // health fail while running
    rd(8'h30, "R9");
    rd(8'h80, "R9");
    rd(8'h04, "R9");
    wr(8'h00, 32'h1, "R9");
    idle(3, "R9");
    rd(8'h30, "R9");
    wr(8'h00, 32'h0, "R9");
    rd(8'h30, "R9");
    rd(8'h04, "R9");
    wr(8'h00, 32'h101, "R5");
    rd(8'h04, "R5");
    rd(8'h30, "R5");
    rd(8'h80, "R5");
    rd(8'h00, "R5");
    step(0, 0, 0, 0, 1, "R5");
    wr(8'h00, 32'h1, "R5");
    for (int i = 0; i < 3; i++) rd(8'h30, "R5");
    idle(WARMUP + DEPTH + 4, "R7");
    rd(8'h30, "R8");
    for (int i = 0; i < 4; i++) rd(8'h80, "R7");
    wr(8'h00, 32'h0, "R4");
    for (int i = 0; i < DEPTH + 2; i++) rd(8'h80, "R4");
    rd(8'h04, "R4");
    step(0, 0, 0, 0, 1, "R9");          // health fail ignored in reset
    rd(8'h30, "R9");
    idle(2, "R10");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule